// File: doc/BRIEF.md
# Dual-Layer Video Priority Mixer

This block takes the pixel streams of two video display controllers and merges them into one 9-bit colour-RAM index, at one pixel per pixel clock. Each input pixel carries a sprite/background flag, a 4-bit palette number and a 4-bit colour. The block picks one of the two pixels, or nothing, and passes it through unchanged. A 4-bit control nibble drives that choice. The nibble holds an enable for each source and a 2-bit priority mode. Some modes let one source's sprites sit behind the other source's background.

Two horizontal windows are programmed by width, measured from the left edge of the line. For each pixel, the block checks which windows cover it. That gives one of four regions, and each region has its own control nibble. Software sets the two control bytes and the two window widths through a byte-wide write port. A line-start strobe clears the pixel position and a pixel-valid strobe advances it.

Top module: `vidPrioMixer`

## Requirements
- R1: The output is either 9'h000 or one of the two input pixels, passed through bit for bit. In a pixel, bit 8 set marks a sprite and bit 8 clear marks a background, bits 7-4 are the palette and bits 3-0 are the colour.
- R2: A source pixel is transparent if its colour bits 3-0 are zero or if its source is disabled. When no opaque pixel remains, the output is 9'h000.
- R3: In priority modes 2'b00 and 2'b11, an opaque source-1 pixel wins whether it is a sprite or a background. Otherwise an opaque source-2 pixel wins.
- R4: In priority mode 2'b01, layers are tried from front to back in this order: source-1 sprite, source-2 sprite, source-1 background, source-2 background.
- R5: In priority mode 2'b10, layers are tried from front to back in this order: source-1 background, source-2 sprite, source-2 background, source-1 sprite.
- R6: A window with width W covers pixel index i when W >= 64 and i < W - 64. Any width below 64 switches that window off.
- R7: The region selects the nibble as follows. Both windows covering the pixel selects control byte 0 bits 3-0. Only window 2 selects byte 0 bits 7-4. Only window 1 selects byte 1 bits 3-0. Neither window selects byte 1 bits 7-4.
- R8: In the selected nibble, bit 0 enables source 1, bit 1 enables source 2 and bits 3-2 give the priority mode.
- R9: The pixel index starts at 0 on a line-start strobe. A pixel presented together with that strobe takes index 0. Each valid pixel advances the index by one, and the index saturates at 1023.
- R10: The mixed pixel appears one clock after its pixel-valid strobe, with outValid high. In a cycle after no valid pixel, outValid is low and outPix is 9'h000.
- R11: Write addresses are 0 for control byte 0, 1 for control byte 1, 2 and 3 for the low byte and upper two bits of window 1's width, and 4 and 5 for the same fields of window 2. Writes to addresses 6 and 7 change nothing. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| lineStart | input | 1 | Clears the pixel index at the start of a line |
| pixValid | input | 1 | A pixel pair is present on the source inputs |
| src1Pix | input | 9 | Pixel from source 1 |
| src2Pix | input | 9 | Pixel from source 2 |
| outPix | output | 9 | Mixed colour-RAM index |
| outValid | output | 1 | outPix holds a mixed pixel |

## Verification
The bench uses the default parameters: a 10-bit window width, a window base of 64 and 9-bit pixels. These values are small enough to sweep every one of the 16 control nibbles against sixteen sprite, background and transparent pixel pairs. They are also small enough to stream a full line past index 1023, which shows whether the index saturates or wraps back into an active window. Several pairs of window widths are streamed: widths just above the base, the two windows swapped, windows switched off, and full-line windows. Each pixel is compared against a region-and-priority model built from the requirements.

// File: rtl/vidmix_pkg.sv
package vidmix_pkg;
  // Strobes and decoded controls handed from the control unit to the datapath
  typedef struct packed {
    logic       pixStb;
    logic       en1;
    logic       en2;
    logic [1:0] mode;
  } mixCtl_t;

  localparam logic [1:0] MODE_S1_OVER = 2'b00;
  localparam logic [1:0] MODE_SPR_UP  = 2'b01;
  localparam logic [1:0] MODE_S1BG_UP = 2'b10;
  localparam logic [1:0] MODE_S1_ALT  = 2'b11;
endpackage

// File: rtl/vidmix_ctrl.sv
module vidmix_ctrl
  import vidmix_pkg::*;
#(
  parameter int WIN_W    = 10,
  parameter int WIN_BASE = 64,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              lineStart,
  input  logic              pixValid,
  output mixCtl_t           ctl
);
  localparam int HI_W = WIN_W - 8;
  localparam logic [WIN_W-1:0] BASE_V  = WIN_W'(WIN_BASE);
  localparam logic [WIN_W-1:0] CNT_MAX = {WIN_W{1'b1}};

  logic [7:0]       ctrlByte [2];
  logic [WIN_W-1:0] winWidth [2];
  logic [WIN_W-1:0] pixCnt;
  logic [WIN_W-1:0] curIdx;
  logic [1:0]       winAct;
  logic [3:0]       nibble;

  // Register file: two control bytes, two split window widths
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlByte[0] <= '0;
      ctrlByte[1] <= '0;
      winWidth[0] <= '0;
      winWidth[1] <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(0): ctrlByte[0] <= wrData;
        ADDR_W'(1): ctrlByte[1] <= wrData;
        ADDR_W'(2): winWidth[0][7:0] <= wrData;
        ADDR_W'(3): winWidth[0][WIN_W-1:8] <= wrData[HI_W-1:0];
        ADDR_W'(4): winWidth[1][7:0] <= wrData;
        ADDR_W'(5): winWidth[1][WIN_W-1:8] <= wrData[HI_W-1:0];
        default: ;
      endcase
    end
  end

  // Pixel position along the line
  assign curIdx = lineStart ? '0 : pixCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt <= '0;
    end else if (lineStart) begin
      pixCnt <= pixValid ? WIN_W'(1) : '0;
    end else if (pixValid && pixCnt != CNT_MAX) begin
      pixCnt <= pixCnt + 1'b1;
    end
  end

  // One comparator per window
  for (genvar k = 0; k < 2; k++) begin : g_win
    assign winAct[k] = (winWidth[k] >= BASE_V) && (curIdx < (winWidth[k] - BASE_V));
  end

  // Region picks the nibble: {window2, window1}
  always_comb begin
    case (winAct)
      2'b11:   nibble = ctrlByte[0][3:0];
      2'b10:   nibble = ctrlByte[0][7:4];
      2'b01:   nibble = ctrlByte[1][3:0];
      default: nibble = ctrlByte[1][7:4];
    endcase
  end

  assign ctl.pixStb = pixValid;
  assign ctl.en1    = nibble[0];
  assign ctl.en2    = nibble[1];
  assign ctl.mode   = nibble[3:2];

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    lineStart && !pixValid |=> pixCnt == '0); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart && pixValid && pixCnt != CNT_MAX |=> pixCnt == $past(pixCnt) + 1'b1); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart && pixCnt == CNT_MAX |=> pixCnt == CNT_MAX); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart && !pixValid |=> $stable(pixCnt)); // R9
endmodule

// File: rtl/vidmix_path.sv
module vidmix_path
  import vidmix_pkg::*;
#(
  parameter int PIX_W = 9,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  mixCtl_t          ctl,
  input  logic [PIX_W-1:0] src1Pix,
  input  logic [PIX_W-1:0] src2Pix,
  output logic [PIX_W-1:0] outPix,
  output logic             outValid
);
  localparam int SPR_BIT = PIX_W - 1;

  logic op1, op2, spr1, spr2;
  logic [PIX_W-1:0] mixed;

  assign op1  = ctl.en1 && (src1Pix[COL_W-1:0] != '0);
  assign op2  = ctl.en2 && (src2Pix[COL_W-1:0] != '0);
  assign spr1 = src1Pix[SPR_BIT];
  assign spr2 = src2Pix[SPR_BIT];

  always_comb begin
    mixed = '0;
    case (ctl.mode)
      MODE_SPR_UP: begin
        if (op1 && spr1)      mixed = src1Pix;
        else if (op2 && spr2) mixed = src2Pix;
        else if (op1)         mixed = src1Pix;
        else if (op2)         mixed = src2Pix;
      end
      MODE_S1BG_UP: begin
        if (op1 && !spr1)     mixed = src1Pix;
        else if (op2)         mixed = src2Pix;
        else if (op1)         mixed = src1Pix;
      end
      default: begin
        if (op1)              mixed = src1Pix;
        else if (op2)         mixed = src2Pix;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPix   <= '0;
      outValid <= 1'b0;
    end else begin
      outPix   <= ctl.pixStb ? mixed : '0;
      outValid <= ctl.pixStb;
    end
  end

  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pixStb |=> outValid); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.pixStb |=> !outValid && outPix == '0); // R10
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pixStb |=> outPix == '0 || outPix == $past(src1Pix) || outPix == $past(src2Pix)); // R1
  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pixStb && !ctl.en1 && !ctl.en2 |=> outPix == '0); // R2
  AST_OPAQUE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    outPix != '0 |-> outPix[COL_W-1:0] != '0); // R2
endmodule

// File: rtl/vidPrioMixer.sv
module vidPrioMixer
  import vidmix_pkg::*;
#(
  parameter int PIX_W    = 9,
  parameter int WIN_W    = 10,
  parameter int WIN_BASE = 64,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              lineStart,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  src1Pix,
  input  logic [PIX_W-1:0]  src2Pix,
  output logic [PIX_W-1:0]  outPix,
  output logic              outValid
);
  mixCtl_t mixCtl;

  vidmix_ctrl #(
    .WIN_W(WIN_W), .WIN_BASE(WIN_BASE), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lineStart(lineStart), .pixValid(pixValid), .ctl(mixCtl)
  );

  vidmix_path #(
    .PIX_W(PIX_W), .COL_W(4)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(mixCtl), .src1Pix(src1Pix), .src2Pix(src2Pix),
    .outPix(outPix), .outValid(outValid)
  );
endmodule

// File: tb/vidPrioMixer_tb.sv
`timescale 1ns/1ps
module vidPrioMixer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       lineStart = 1'b0;
  logic       pixValid = 1'b0;
  logic [8:0] src1Pix = '0;
  logic [8:0] src2Pix = '0;
  logic [8:0] outPix;
  logic       outValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] shC0 = '0, shC1 = '0;
  int         shW1 = 0, shW2 = 0;

  always #2.5 clk = ~clk;

  vidPrioMixer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lineStart(lineStart), .pixValid(pixValid), .src1Pix(src1Pix), .src2Pix(src2Pix),
    .outPix(outPix), .outValid(outValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Priority model from R2-R5, R8
  function automatic logic [8:0] mixModel(input logic [8:0] a, input logic [8:0] b, input logic [3:0] nib);
    bit oa = nib[0] && (a[3:0] != 0);
    bit ob = nib[1] && (b[3:0] != 0);
    logic [8:0] r = 9'h000;
    case (nib[3:2])
      2'b01: begin
        if (oa && a[8]) r = a; else if (ob && b[8]) r = b; else if (oa) r = a; else if (ob) r = b;
      end
      2'b10: begin
        if (oa && !a[8]) r = a; else if (ob && b[8]) r = b; else if (ob) r = b; else if (oa) r = a;
      end
      default: begin
        if (oa) r = a; else if (ob) r = b;
      end
    endcase
    return r;
  endfunction

  // Region model from R6, R7
  function automatic logic [3:0] pickNib(input int idx);
    bit a1 = (shW1 >= 64) && (idx < shW1 - 64);
    bit a2 = (shW2 >= 64) && (idx < shW2 - 64);
    if (a1 && a2) return shC0[3:0];
    if (a2)       return shC0[7:4];
    if (a1)       return shC1[3:0];
    return shC1[7:4];
  endfunction

  function automatic string modeTag(input logic [3:0] nib);
    if (nib[3:2] == 2'b01) return "R4";
    if (nib[3:2] == 2'b10) return "R5";
    return "R3";
  endfunction

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      0: shC0 = 8'(d);
      1: shC1 = 8'(d);
      2: shW1 = (shW1 & 32'h300) | (d & 8'hFF);
      3: shW1 = (shW1 & 32'h0FF) | ((d & 3) << 8);
      4: shW2 = (shW2 & 32'h300) | (d & 8'hFF);
      5: shW2 = (shW2 & 32'h0FF) | ((d & 3) << 8);
      default: ;
    endcase
  endtask

  task automatic setWins(input int w1, input int w2);
    writeReg(2, w1 & 8'hFF); writeReg(3, w1 >> 8);
    writeReg(4, w2 & 8'hFF); writeReg(5, w2 >> 8);
  endtask

  // Drive one pixel pair and check it one clock later
  task automatic pushPix(input bit ls, input logic [8:0] a, input logic [8:0] b,
                         input logic [8:0] exp, input string req);
    @(negedge clk);
    lineStart = ls; pixValid = 1'b1; src1Pix = a; src2Pix = b;
    @(posedge clk);
    #1;
    check(outValid === 1'b1, "R10", int'(outValid), 1);
    check(outPix === exp, req, int'(outPix), int'(exp));
  endtask

  task automatic idleCheck();
    @(negedge clk);
    lineStart = 1'b0; pixValid = 1'b0; src1Pix = 9'h1FF; src2Pix = 9'h1FF;
    @(posedge clk);
    #1;
    check(outValid === 1'b0 && outPix === 9'h000, "R10", int'({outValid, outPix}), 0);
  endtask

  // Stream a line; a second line-start may fire at restartAt
  task automatic streamLine(input int n, input int seed, input int restartAt, input string req);
    int idx = 0;
    for (int i = 0; i < n; i++) begin
      bit ls = (i == 0) || (i == restartAt);
      logic [8:0] a = 9'((i * 37 + seed) % 512);
      logic [8:0] b = 9'((i * 91 + seed * 3 + 7) % 512);
      int useIdx = ls ? 0 : idx;
      pushPix(ls, a, b, mixModel(a, b, pickNib(useIdx)), req);
      idx = (useIdx < 1023) ? useIdx + 1 : 1023;
    end
    idleCheck();
  endtask

  initial begin
    logic [8:0] cls [4];
    cls[0] = 9'h030; cls[1] = 9'h035; cls[2] = 9'h1A7; cls[3] = 9'h100;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R11 / R10: reset state
    check(outPix === 9'h000 && outValid === 1'b0, "R11", int'({outValid, outPix}), 0);
    // R11: registers reset to zero, so every pixel mixes to nothing
    streamLine(8, 3, -1, "R11");

    // R3 R4 R5 R2 R8: every nibble against sprite/background/transparent pairs, no window
    for (int nib = 0; nib < 16; nib++) begin
      writeReg(1, nib << 4);
      for (int x = 0; x < 4; x++)
        for (int y = 0; y < 4; y++)
          pushPix(1'b1, cls[x], cls[y], mixModel(cls[x], cls[y], 4'(nib)), modeTag(4'(nib)));
      idleCheck();
    end

    // R6 R7: windows just above base, then swapped
    writeReg(0, 8'h9E); writeReg(1, 8'h57);
    setWins(66, 68);
    streamLine(12, 11, -1, "R7");
    setWins(68, 66);
    streamLine(12, 29, -1, "R7");
    // R6: widths below 64 switch windows off
    setWins(63, 0);
    streamLine(12, 5, -1, "R6");
    // R6 R9: full-line window and saturation beyond 1023; restart mid-line
    writeReg(0, 8'hB7); writeReg(1, 8'h6D);
    setWins(1023, 100);
    streamLine(1100, 41, -1, "R9");
    streamLine(200, 77, 150, "R9");
    setWins(300, 500);
    streamLine(600, 13, -1, "R6");
    // R11: addresses 6 and 7 leave state untouched
    writeReg(6, 8'hFF); writeReg(7, 8'h00);
    streamLine(600, 13, -1, "R11");
    // R1: pass-through with every enable on and varied pixels
    writeReg(0, 8'hFF); writeReg(1, 8'h33);
    setWins(80, 90);
    streamLine(64, 99, -1, "R1");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule